// File: doc/BRIEF.md
# Router Forwarding Decision Controller

This block makes the per-packet forwarding decision inside the output lookup stage of an IPv4 router. Six preprocessing units each present a result with a valid flag: the metadata header parser, the Ethernet parser, the header checksum and TTL checker, the destination address filter, the route lookup and the ARP lookup. The controller waits until all six flags are high. In that cycle it pulses one read strobe to every source and evaluates a fixed chain of exceptions. The packet then goes to a MAC port, goes to a CPU queue, or is dropped.

The output port is an eight-bit one-hot vector: MAC port `p` is bit `2p` and the CPU queue paired with it is bit `2p+1`. When a packet is forwarded to a MAC port, the decision also carries a rewrite request: the decremented TTL, the updated checksum, the next-hop MAC from ARP and the source MAC of the egress port. A send decision leaves on a valid/ready interface. `dec_valid` stays high and every decision field stays constant until `dec_ready` is seen high at a clock edge. While a decision is waiting, no new inputs are accepted. A drop produces a single-cycle `pkt_drop` pulse. It needs no handshake and carries no port.

Top module: `fwd_decide`

## Requirements
- R1: While `rst_n` is low and after reset, `dec_valid`, `pkt_drop` and all six read strobes are 0.
- R2: A decision is taken only in an idle cycle in which all six valid flags are high. In that one cycle all six read strobes are 1, and they are 0 in every other cycle. The decision appears on the outputs from the following cycle.
- R3: A packet flagged as coming from the CPU is sent to `hdr_cpu_oport` with `dec_rewrite`=0, whatever the other results are.
- R4: When the destination MAC is neither ours nor broadcast, `pkt_drop` is 1 for exactly one cycle, `dec_valid` stays 0, and the block is idle again in the next cycle.
- R5: A non-IP frame addressed to us or broadcast goes to CPU queue bit `2*hdr_in_port+1`.
- R6: An IP frame that is broadcast but not addressed to us goes to the paired CPU queue.
- R7: An IP frame addressed to us with a bad header checksum is dropped as in R4, even when other checks also fail.
- R8: Otherwise, if the version is not 4, options are present or the TTL check fails, the packet goes to the paired CPU queue.
- R9: Otherwise, a hit in the destination filter sends the packet to the paired CPU queue.
- R10: Otherwise, a route miss or an ARP miss sends the packet to the paired CPU queue.
- R11: Otherwise, the packet goes to `lpm_oport` (an even bit) with `dec_rewrite`=1. The decision carries `ck_new_ttl`, `ck_new_csum`, `arp_mac`, and the source MAC `own_macs[48p +: 48]` of egress port `p`. For every decision without a rewrite, these four fields are 0.
- R12: While `dec_valid` is 1 and `dec_ready` is 0, the decision fields stay unchanged and no read strobe is issued. The block returns to idle in the cycle after `dec_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_vld | input | 1 | Metadata parser result valid |
| hdr_from_cpu | input | 1 | Packet was injected by the CPU |
| hdr_cpu_oport | input | 8 | One-hot port chosen by the CPU |
| hdr_in_port | input | 2 | Index of the ingress MAC port |
| hdr_rd | output | 1 | Read strobe to the metadata parser |
| eth_vld | input | 1 | Ethernet parser result valid |
| eth_is_ip | input | 1 | Ethertype is IPv4 |
| eth_for_us | input | 1 | Destination MAC is the ingress port's address |
| eth_bcast | input | 1 | Destination MAC is broadcast |
| eth_rd | output | 1 | Read strobe to the Ethernet parser |
| ck_vld | input | 1 | Checksum/TTL result valid |
| ck_good | input | 1 | Header checksum correct |
| ck_ver4 | input | 1 | IP version is 4 |
| ck_opts | input | 1 | Header carries options |
| ck_ttl_ok | input | 1 | TTL greater than 1 |
| ck_new_ttl | input | 8 | Decremented TTL |
| ck_new_csum | input | 16 | Updated header checksum |
| ck_rd | output | 1 | Read strobe to the checksum unit |
| flt_vld | input | 1 | Filter result valid |
| flt_hit | input | 1 | Destination IP is in the local filter |
| flt_rd | output | 1 | Read strobe to the filter |
| lpm_vld | input | 1 | Route result valid |
| lpm_hit | input | 1 | Route found |
| lpm_oport | input | 8 | One-hot egress MAC port of the route |
| lpm_rd | output | 1 | Read strobe to the route lookup |
| arp_vld | input | 1 | ARP result valid |
| arp_hit | input | 1 | Next-hop MAC found |
| arp_mac | input | 48 | Next-hop MAC address |
| arp_rd | output | 1 | Read strobe to the ARP lookup |
| own_macs | input | 192 | Per-port router MAC addresses, port p at bits 48p upward |
| dec_valid | output | 1 | Send decision valid |
| dec_ready | input | 1 | Consumer accepts the decision |
| dec_oport | output | 8 | One-hot output port |
| dec_rewrite | output | 1 | Header rewrite requested |
| dec_new_ttl | output | 8 | TTL to write |
| dec_new_csum | output | 16 | Checksum to write |
| dec_dst_mac | output | 48 | New destination MAC |
| dec_src_mac | output | 48 | New source MAC |
| pkt_drop | output | 1 | One-cycle drop indication |

## Verification
The assertions take for granted that each source holds its valid flag and result steady until it sees its read strobe. They also assume that `lpm_oport` names a single even bit whenever `lpm_hit` is 1, and that `hdr_cpu_oport` is one-hot. The stimulus meets these conditions. Every packet's results stay in place until the strobe is observed, and the flags are cleared on the next edge. Results sometimes arrive staggered, with one flag held back for several cycles. Route results always carry one MAC port bit, and CPU-injected packets always carry one port bit. Ready is driven in three patterns (always high, alternating, and mostly low) so that decisions are held and released under back-pressure.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Outcome of the exception chain for one packet.
  typedef enum logic [1:0] {
    ACT_MAC  = 2'd0,
    ACT_CPU  = 2'd1,
    ACT_DROP = 2'd2
  } act_e;

  // Sequencer states.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DROP = 2'd2
  } st_e;

endpackage

// File: rtl/fwd_classify.sv
module fwd_classify
  import fwd_pkg::*;
#(
  parameter int NUM_MAC = 4,
  localparam int OPORT_W = 2 * NUM_MAC,
  localparam int PIDX_W = (NUM_MAC > 1) ? $clog2(NUM_MAC) : 1
) (
  input  logic               from_cpu,
  input  logic [OPORT_W-1:0] cpu_oport,
  input  logic [PIDX_W-1:0]  in_port,
  input  logic               is_ip,
  input  logic               for_us,
  input  logic               bcast,
  input  logic               ck_good,
  input  logic               ver4,
  input  logic               opts,
  input  logic               ttl_ok,
  input  logic               flt_hit,
  input  logic               lpm_hit,
  input  logic [OPORT_W-1:0] lpm_oport,
  input  logic               arp_hit,
  output act_e               act,
  output logic [OPORT_W-1:0] oport,
  output logic               rewrite
);

  logic [OPORT_W-1:0] cpu_q;

  // CPU queue paired with the ingress MAC port sits on the odd bit above it.
  always_comb begin
    cpu_q = '0;
    for (int i = 0; i < NUM_MAC; i++) begin
      if (in_port == PIDX_W'(i)) cpu_q[2*i+1] = 1'b1;
    end
  end

  // Ordered exception chain; the first matching condition wins.
  always_comb begin
    act     = ACT_CPU;
    oport   = cpu_q;
    rewrite = 1'b0;
    if (from_cpu) begin
      act   = ACT_MAC;
      oport = cpu_oport;
    end else if (!for_us && !bcast) begin
      act   = ACT_DROP;
      oport = '0;
    end else if (!is_ip) begin
      act = ACT_CPU;
    end else if (!for_us) begin
      act = ACT_CPU;
    end else if (!ck_good) begin
      act   = ACT_DROP;
      oport = '0;
    end else if (!ver4 || opts || !ttl_ok) begin
      act = ACT_CPU;
    end else if (flt_hit) begin
      act = ACT_CPU;
    end else if (!lpm_hit || !arp_hit) begin
      act = ACT_CPU;
    end else begin
      act     = ACT_MAC;
      oport   = lpm_oport;
      rewrite = 1'b1;
    end
  end

endmodule

// File: rtl/fwd_rewrite.sv
module fwd_rewrite #(
  parameter int NUM_MAC = 4,
  parameter int TTL_W   = 8,
  parameter int CSUM_W  = 16,
  parameter int MAC_W   = 48
) (
  input  logic                     rewrite,
  input  logic [NUM_MAC-1:0]       egress_sel,
  input  logic [NUM_MAC*MAC_W-1:0] own_macs,
  input  logic [MAC_W-1:0]         arp_mac,
  input  logic [TTL_W-1:0]         new_ttl,
  input  logic [CSUM_W-1:0]        new_csum,
  output logic [TTL_W-1:0]         w_ttl,
  output logic [CSUM_W-1:0]        w_csum,
  output logic [MAC_W-1:0]         w_dst,
  output logic [MAC_W-1:0]         w_src
);

  logic [MAC_W-1:0] port_mac;

  // Egress port's own address, selected by its one-hot MAC bit.
  always_comb begin
    port_mac = '0;
    for (int i = 0; i < NUM_MAC; i++) begin
      if (egress_sel[i]) port_mac = own_macs[i*MAC_W +: MAC_W];
    end
  end

  always_comb begin
    if (rewrite) begin
      w_ttl  = new_ttl;
      w_csum = new_csum;
      w_dst  = arp_mac;
      w_src  = port_mac;
    end else begin
      w_ttl  = '0;
      w_csum = '0;
      w_dst  = '0;
      w_src  = '0;
    end
  end

endmodule

// File: rtl/fwd_seq.sv
module fwd_seq
  import fwd_pkg::*;
#(
  parameter int OPORT_W = 8,
  parameter int TTL_W   = 8,
  parameter int CSUM_W  = 16,
  parameter int MAC_W   = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               all_vld,
  input  act_e               act,
  input  logic [OPORT_W-1:0] oport,
  input  logic               rewrite,
  input  logic [TTL_W-1:0]   w_ttl,
  input  logic [CSUM_W-1:0]  w_csum,
  input  logic [MAC_W-1:0]   w_dst,
  input  logic [MAC_W-1:0]   w_src,
  input  logic               dec_ready,
  output logic               take,
  output logic               dec_valid,
  output logic               pkt_drop,
  output logic [OPORT_W-1:0] q_oport,
  output logic               q_rewrite,
  output logic [TTL_W-1:0]   q_ttl,
  output logic [CSUM_W-1:0]  q_csum,
  output logic [MAC_W-1:0]   q_dst,
  output logic [MAC_W-1:0]   q_src
);

  st_e st, st_nx;

  assign take      = (st == ST_IDLE) && all_vld;
  assign dec_valid = (st == ST_SEND);
  assign pkt_drop  = (st == ST_DROP);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (take) st_nx = (act == ACT_DROP) ? ST_DROP : ST_SEND;
      ST_SEND: if (dec_ready) st_nx = ST_IDLE;
      ST_DROP: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // Decision bundle is captured once and held through back-pressure.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_oport   <= '0;
      q_rewrite <= 1'b0;
      q_ttl     <= '0;
      q_csum    <= '0;
      q_dst     <= '0;
      q_src     <= '0;
    end else if (take && act != ACT_DROP) begin
      q_oport   <= oport;
      q_rewrite <= rewrite;
      q_ttl     <= w_ttl;
      q_csum    <= w_csum;
      q_dst     <= w_dst;
      q_src     <= w_src;
    end
  end

endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
  import fwd_pkg::*;
#(
  parameter int NUM_MAC = 4,
  parameter int TTL_W   = 8,
  parameter int CSUM_W  = 16,
  parameter int MAC_W   = 48,
  localparam int OPORT_W = 2 * NUM_MAC,
  localparam int PIDX_W = (NUM_MAC > 1) ? $clog2(NUM_MAC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hdr_vld,
  input  logic                     hdr_from_cpu,
  input  logic [OPORT_W-1:0]       hdr_cpu_oport,
  input  logic [PIDX_W-1:0]        hdr_in_port,
  output logic                     hdr_rd,
  input  logic                     eth_vld,
  input  logic                     eth_is_ip,
  input  logic                     eth_for_us,
  input  logic                     eth_bcast,
  output logic                     eth_rd,
  input  logic                     ck_vld,
  input  logic                     ck_good,
  input  logic                     ck_ver4,
  input  logic                     ck_opts,
  input  logic                     ck_ttl_ok,
  input  logic [TTL_W-1:0]         ck_new_ttl,
  input  logic [CSUM_W-1:0]        ck_new_csum,
  output logic                     ck_rd,
  input  logic                     flt_vld,
  input  logic                     flt_hit,
  output logic                     flt_rd,
  input  logic                     lpm_vld,
  input  logic                     lpm_hit,
  input  logic [OPORT_W-1:0]       lpm_oport,
  output logic                     lpm_rd,
  input  logic                     arp_vld,
  input  logic                     arp_hit,
  input  logic [MAC_W-1:0]         arp_mac,
  output logic                     arp_rd,
  input  logic [NUM_MAC*MAC_W-1:0] own_macs,
  output logic                     dec_valid,
  input  logic                     dec_ready,
  output logic [OPORT_W-1:0]       dec_oport,
  output logic                     dec_rewrite,
  output logic [TTL_W-1:0]         dec_new_ttl,
  output logic [CSUM_W-1:0]        dec_new_csum,
  output logic [MAC_W-1:0]         dec_dst_mac,
  output logic [MAC_W-1:0]         dec_src_mac,
  output logic                     pkt_drop
);

  logic               all_vld;
  logic               take;
  act_e               act;
  logic [OPORT_W-1:0] c_oport;
  logic               c_rewrite;
  logic [NUM_MAC-1:0] egress_sel;
  logic [TTL_W-1:0]   w_ttl;
  logic [CSUM_W-1:0]  w_csum;
  logic [MAC_W-1:0]   w_dst;
  logic [MAC_W-1:0]   w_src;

  assign all_vld = hdr_vld & eth_vld & ck_vld & flt_vld & lpm_vld & arp_vld;

  // Even bits of the route port vector name the MAC ports.
  for (genvar g = 0; g < NUM_MAC; g++) begin : g_egress
    assign egress_sel[g] = lpm_oport[2*g];
  end

  fwd_classify #(.NUM_MAC(NUM_MAC)) u_classify (
    .from_cpu  (hdr_from_cpu),
    .cpu_oport (hdr_cpu_oport),
    .in_port   (hdr_in_port),
    .is_ip     (eth_is_ip),
    .for_us    (eth_for_us),
    .bcast     (eth_bcast),
    .ck_good   (ck_good),
    .ver4      (ck_ver4),
    .opts      (ck_opts),
    .ttl_ok    (ck_ttl_ok),
    .flt_hit   (flt_hit),
    .lpm_hit   (lpm_hit),
    .lpm_oport (lpm_oport),
    .arp_hit   (arp_hit),
    .act       (act),
    .oport     (c_oport),
    .rewrite   (c_rewrite)
  );

  fwd_rewrite #(
    .NUM_MAC(NUM_MAC), .TTL_W(TTL_W), .CSUM_W(CSUM_W), .MAC_W(MAC_W)
  ) u_rewrite (
    .rewrite    (c_rewrite),
    .egress_sel (egress_sel),
    .own_macs   (own_macs),
    .arp_mac    (arp_mac),
    .new_ttl    (ck_new_ttl),
    .new_csum   (ck_new_csum),
    .w_ttl      (w_ttl),
    .w_csum     (w_csum),
    .w_dst      (w_dst),
    .w_src      (w_src)
  );

  fwd_seq #(
    .OPORT_W(OPORT_W), .TTL_W(TTL_W), .CSUM_W(CSUM_W), .MAC_W(MAC_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_vld   (all_vld),
    .act       (act),
    .oport     (c_oport),
    .rewrite   (c_rewrite),
    .w_ttl     (w_ttl),
    .w_csum    (w_csum),
    .w_dst     (w_dst),
    .w_src     (w_src),
    .dec_ready (dec_ready),
    .take      (take),
    .dec_valid (dec_valid),
    .pkt_drop  (pkt_drop),
    .q_oport   (dec_oport),
    .q_rewrite (dec_rewrite),
    .q_ttl     (dec_new_ttl),
    .q_csum    (dec_new_csum),
    .q_dst     (dec_dst_mac),
    .q_src     (dec_src_mac)
  );

  // One strobe per source, all in the decision cycle.
  assign hdr_rd = take;
  assign eth_rd = take;
  assign ck_rd  = take;
  assign flt_rd = take;
  assign lpm_rd = take;
  assign arp_rd = take;

endmodule

// File: rtl/fwd_decide_chk.sv
module fwd_decide_chk #(
  parameter int OPORT_W = 8,
  parameter int MAC_W   = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hdr_vld,
  input logic               eth_vld,
  input logic               ck_vld,
  input logic               flt_vld,
  input logic               lpm_vld,
  input logic               arp_vld,
  input logic               hdr_rd,
  input logic               dec_valid,
  input logic               dec_ready,
  input logic [OPORT_W-1:0] dec_oport,
  input logic               dec_rewrite,
  input logic [MAC_W-1:0]   dec_dst_mac,
  input logic               pkt_drop
);

  logic odd_set;
  always_comb begin
    odd_set = 1'b0;
    for (int i = 1; i < OPORT_W; i += 2) odd_set = odd_set | dec_oport[i];
  end

  assert_strobe_needs_inputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_rd |-> (hdr_vld && eth_vld && ck_vld && flt_vld && lpm_vld && arp_vld));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_rd |=> !hdr_rd);

  assert_result_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) || $rose(pkt_drop)) |-> $past(hdr_rd));

  assert_no_strobe_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid || pkt_drop) |-> !hdr_rd);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_oport) &&
                                   $stable(dec_rewrite) && $stable(dec_dst_mac)));

  assert_drop_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drop |=> (!pkt_drop && !dec_valid));

  assert_drop_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_drop && dec_valid));

  assert_oport_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones(dec_oport) == 1));

  assert_fwd_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_rewrite) |-> !odd_set);

endmodule

bind fwd_decide fwd_decide_chk #(.OPORT_W(2 * NUM_MAC), .MAC_W(MAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hdr_vld     (hdr_vld),
  .eth_vld     (eth_vld),
  .ck_vld      (ck_vld),
  .flt_vld     (flt_vld),
  .lpm_vld     (lpm_vld),
  .arp_vld     (arp_vld),
  .hdr_rd      (hdr_rd),
  .dec_valid   (dec_valid),
  .dec_ready   (dec_ready),
  .dec_oport   (dec_oport),
  .dec_rewrite (dec_rewrite),
  .dec_dst_mac (dec_dst_mac),
  .pkt_drop    (pkt_drop)
);

// File: tb/fwd_decide_bench.sv
module fwd_decide_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic hv = 0, ev = 0, cv = 0, fv = 0, lv = 0, av = 0;
  logic s_from_cpu = 0;
  logic [7:0] s_cpu_op = 0;
  logic [1:0] s_in_port = 0;
  logic s_is_ip = 0, s_for_us = 0, s_bcast = 0;
  logic s_good = 0, s_ver4 = 0, s_opts = 0, s_ttl_ok = 0;
  logic [7:0] s_ttl = 0;
  logic [15:0] s_csum = 0;
  logic s_flt = 0, s_lpm_hit = 0, s_arp_hit = 0;
  logic [7:0] s_lpm_op = 0;
  logic [47:0] s_arp_mac = 0;
  logic [191:0] own_macs;
  logic dec_ready = 0;

  logic hdr_rd, eth_rd, ck_rd, flt_rd, lpm_rd, arp_rd;
  logic dec_valid, dec_rewrite, pkt_drop;
  logic [7:0] dec_oport, dec_new_ttl;
  logic [15:0] dec_new_csum;
  logic [47:0] dec_dst_mac, dec_src_mac;

  initial begin
    for (int i = 0; i < 4; i++) own_macs[i*48 +: 48] = 48'h0200_5E00_1000 + 48'(i * 17 + 3);
  end

  fwd_decide u_fwd_decide (
    .clk(clk), .rst_n(rst_n),
    .hdr_vld(hv), .hdr_from_cpu(s_from_cpu), .hdr_cpu_oport(s_cpu_op),
    .hdr_in_port(s_in_port), .hdr_rd(hdr_rd),
    .eth_vld(ev), .eth_is_ip(s_is_ip), .eth_for_us(s_for_us), .eth_bcast(s_bcast),
    .eth_rd(eth_rd),
    .ck_vld(cv), .ck_good(s_good), .ck_ver4(s_ver4), .ck_opts(s_opts),
    .ck_ttl_ok(s_ttl_ok), .ck_new_ttl(s_ttl), .ck_new_csum(s_csum), .ck_rd(ck_rd),
    .flt_vld(fv), .flt_hit(s_flt), .flt_rd(flt_rd),
    .lpm_vld(lv), .lpm_hit(s_lpm_hit), .lpm_oport(s_lpm_op), .lpm_rd(lpm_rd),
    .arp_vld(av), .arp_hit(s_arp_hit), .arp_mac(s_arp_mac), .arp_rd(arp_rd),
    .own_macs(own_macs),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_oport(dec_oport),
    .dec_rewrite(dec_rewrite), .dec_new_ttl(dec_new_ttl), .dec_new_csum(dec_new_csum),
    .dec_dst_mac(dec_dst_mac), .dec_src_mac(dec_src_mac), .pkt_drop(pkt_drop)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Expected outcome from the requirement list: kind 1 = send, 2 = drop.
  function automatic void ref_decide(output int kind, output logic [7:0] op,
                                     output logic rw, output string tag);
    kind = 1;
    rw   = 1'b0;
    op   = 8'h01 << (2 * int'(s_in_port) + 1);
    if (s_from_cpu) begin op = s_cpu_op; tag = "R3"; end
    else if (!s_for_us && !s_bcast) begin kind = 2; op = 0; tag = "R4"; end
    else if (!s_is_ip) tag = "R5";
    else if (!s_for_us) tag = "R6";
    else if (!s_good) begin kind = 2; op = 0; tag = "R7"; end
    else if (!s_ver4 || s_opts || !s_ttl_ok) tag = "R8";
    else if (s_flt) tag = "R9";
    else if (!s_lpm_hit || !s_arp_hit) tag = "R10";
    else begin op = s_lpm_op; rw = 1'b1; tag = "R11"; end
  endfunction

  // Cycle model: 0 idle, 1 holding a send decision, 2 drop pulse.
  int m_st = 0;
  string m_tag = "R1";
  logic [7:0] m_op = 0, m_ttl = 0;
  logic m_rw = 0;
  logic [15:0] m_csum = 0;
  logic [47:0] m_dst = 0, m_src = 0;

  always @(posedge clk) begin
    int k;
    logic [7:0] op;
    logic rw;
    string tg;
    if (!rst_n) begin
      m_st = 0;
      m_tag = "R1";
    end else begin
      case (m_st)
        0: if (hv && ev && cv && fv && lv && av) begin
             ref_decide(k, op, rw, tg);
             m_tag = tg;
             if (k == 2) m_st = 2;
             else begin
               m_st = 1;
               m_op = op;
               m_rw = rw;
               m_ttl = rw ? s_ttl : 8'h0;
               m_csum = rw ? s_csum : 16'h0;
               m_dst = rw ? s_arp_mac : 48'h0;
               m_src = 48'h0;
               if (rw)
                 for (int i = 0; i < 4; i++)
                   if (s_lpm_op[2*i]) m_src = own_macs[i*48 +: 48];
             end
           end
        1: if (dec_ready) m_st = 0; else m_tag = "R12";
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    logic exp_rd;
    string stag;
    exp_rd = rst_n && (m_st == 0) && hv && ev && cv && fv && lv && av;
    stag = !rst_n ? "R1" : ((m_st == 1) ? "R12" : "R2");
    chk({hdr_rd, eth_rd, ck_rd, flt_rd, lpm_rd, arp_rd} == {6{exp_rd}}, stag, "strobes",
        64'({hdr_rd, eth_rd, ck_rd, flt_rd, lpm_rd, arp_rd}), 64'({6{exp_rd}}));
    chk(dec_valid == (m_st == 1), m_tag, "dec_valid", 64'(dec_valid), 64'(m_st == 1));
    chk(pkt_drop == (m_st == 2), m_tag, "pkt_drop", 64'(pkt_drop), 64'(m_st == 2));
    if (m_st == 1) begin
      chk(dec_oport == m_op, m_tag, "oport", 64'(dec_oport), 64'(m_op));
      chk(dec_rewrite == m_rw, m_tag, "rewrite", 64'(dec_rewrite), 64'(m_rw));
      chk(dec_new_ttl == m_ttl, m_tag, "ttl", 64'(dec_new_ttl), 64'(m_ttl));
      chk(dec_new_csum == m_csum, m_tag, "csum", 64'(dec_new_csum), 64'(m_csum));
      chk(dec_dst_mac == m_dst, m_tag, "dst_mac", 64'(dec_dst_mac), 64'(m_dst));
      chk(dec_src_mac == m_src, m_tag, "src_mac", 64'(dec_src_mac), 64'(m_src));
    end
  end

  // Ready patterns: 0 always, 1 alternating, 2 one cycle in four.
  int rdy_mode = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    case (rdy_mode)
      0: dec_ready = 1'b1;
      1: dec_ready = cyc[0];
      default: dec_ready = (cyc[1:0] == 2'd3);
    endcase
  end

  int seq = 0;

  // A packet that passes every check, routed to MAC port p.
  task automatic base(input int p);
    seq++;
    s_from_cpu = 0; s_cpu_op = 0; s_in_port = 2'(3 - p);
    s_is_ip = 1; s_for_us = 1; s_bcast = 0;
    s_good = 1; s_ver4 = 1; s_opts = 0; s_ttl_ok = 1;
    s_ttl = 8'(64 - seq); s_csum = 16'hB000 + 16'(seq * 7);
    s_flt = 0; s_lpm_hit = 1; s_lpm_op = 8'h01 << (2 * p); s_arp_hit = 1;
    s_arp_mac = 48'h00AA_BB00_0000 + 48'(seq);
  endtask

  // Present the results, wait for the strobe, then retire them.
  task automatic go(input bit stagger);
    if (stagger) begin
      {hv, ev, cv, fv, lv} = '1;
      repeat (4) begin @(posedge clk); #1; end
      av = 1;
    end else begin
      {hv, ev, cv, fv, lv, av} = '1;
    end
    do @(negedge clk); while (!hdr_rd);
    @(posedge clk); #1;
    {hv, ev, cv, fv, lv, av} = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    for (int mode = 0; mode < 3; mode++) begin
      rdy_mode = mode;
      for (int p = 0; p < 4; p++) begin
        base(p); go(mode == 1);                                   // R11 forward
        base(p); s_from_cpu = 1; s_cpu_op = 8'h01 << (2 * p);
        s_good = 0; s_for_us = 0; go(0);                          // R3
        base(p); s_for_us = 0; go(0);                             // R4
        base(p); s_is_ip = 0; go(0);                              // R5
        base(p); s_is_ip = 0; s_for_us = 0; s_bcast = 1; go(0);   // R5 broadcast
        base(p); s_for_us = 0; s_bcast = 1; go(0);                // R6
        base(p); s_good = 0; go(0);                               // R7
        base(p); s_good = 0; s_ver4 = 0; s_flt = 1; go(0);        // R7 priority
        base(p); s_ver4 = 0; go(0);                               // R8
        base(p); s_opts = 1; go(0);                               // R8
        base(p); s_ttl_ok = 0; s_lpm_hit = 0; go(0);              // R8
        base(p); s_flt = 1; go(1);                                // R9
        base(p); s_lpm_hit = 0; go(0);                            // R10
        base(p); s_arp_hit = 0; go(0);                            // R10
      end
    end
    rdy_mode = 0;
    repeat (6) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule